// File: doc/BRIEF.md
# SD Host Command Issue and Response Capture

This block holds the command-path registers of an MMC/SD host controller. Software writes a 32-bit command argument as two 16-bit halves and then writes a command word. That write launches the command towards a card-side command engine. The launch is a one-cycle start pulse, and the decoded command fields and the argument are held steady beside it. The same write clears the eight 16-bit response registers. For an addressed-data-transfer command it also pulses a clear for the data FIFO read position.

When the command engine reports the finished exchange, it supplies up to 16 raw response bytes and a byte count. The block packs the bytes big-endian into 16-bit words and stores them in reversed register order. It then sets status bits that depend on the response type:
- end of command, plus a busy indication when the command asked for one;
- a command timeout when an expected response is missing;
- an OCR-busy flag for an R3 response;
- a single card-error flag. It is built from a type-specific mask over the card status.

The status bits are cleared by writing 1s. An interrupt is raised while any enabled status bit is set. A command-timeout setting that the serial engine cannot use is reported on a separate flag.

Top module: `sdh_cmd_top`

## Requirements
- R1: A write to the command register (address 0) produces `cmd_start` high for exactly the one cycle after the write. During that cycle and afterwards, `cmd_index` = bits 5:0, `cmd_rsp_type` = bits 10:8, `cmd_kind` = bits 13:12, `cmd_busy` = bit 11 and `cmd_dir` = bit 15 of the written word. The command word reads back at address 0.
- R2: A write to address 1 replaces argument bits 15:0, and a write to address 2 replaces argument bits 31:16. The other half is left unchanged. `cmd_arg` and the read-back at addresses 1 and 2 show the result.
- R3: A command write sets all eight response registers (addresses 8..15) to zero. When bits 13:12 of the written word equal 3, `fifo_pos_clr` is high in the same cycle as `cmd_start`; otherwise it stays low.
- R4: Byte k of the response is `rsp_bytes[8k+7:8k]`. Response register 7−i (address 8+7−i) receives {byte 2i, byte 2i+1}, with byte 2i in bits 15:8. Registers are loaded only when the response type is nonzero and `rsp_len` is nonzero.
- R5: For response type 1, the card status is {byte0, byte1, byte2, byte3}. Status bit 14 is set when that status has any of bits 31..26, 24..19 set. Bit 3 of the card status also counts when bit 13 of the control register (address 6) is 1.
- R6: For response type 6, status bit 14 is set when {byte2, byte3} has any of bits 15..13 or bit 3 set.
- R7: For response type 3, status bit 12 is set when bit 31 of {byte0..byte3} is 0.
- R8: A response with a nonzero type and `rsp_len` = 0 sets status bit 7 (timeout) and sets neither bit 0 nor bit 2.
- R9: Any other accepted response sets status bit 0, and also sets bit 2 when the command had bit 11 set. Response type 0 stores nothing.
- R10: `cto_illegal` is 1 exactly while the timeout register (address 5, bits 7:0) holds 0xFE or 0xFF.
- R11: Writing the status register (address 3) clears each bit written as 1, and a status bit being set at the same moment takes priority. `irq` is 1 while (status AND enable register at address 4) is nonzero, and it follows a status write on the next cycle.
- R12: A response strobe that arrives when no command is outstanding, or in the same cycle as a new command write, changes neither the status nor the response registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register word address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for `host_addr` (combinational) |
| irq | output | 1 | Interrupt: enabled status bit set |
| cto_illegal | output | 1 | Timeout setting unusable |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_index | output | 6 | Command index |
| cmd_rsp_type | output | 3 | Expected response type |
| cmd_kind | output | 2 | Command type |
| cmd_busy | output | 1 | Command expects busy signalling |
| cmd_dir | output | 1 | Data direction |
| cmd_arg | output | 32 | Command argument |
| fifo_pos_clr | output | 1 | Reset FIFO read position for a data-transfer command |
| rsp_valid | input | 1 | Response completion strobe from command engine |
| rsp_len | input | 5 | Response byte count, 0 = no response |
| rsp_bytes | input | 128 | Raw response bytes, byte k at bits 8k+7:8k |

## Verification
Random commands cover response types 0, 1, 2, 3 and 6. The busy flag varies, and so does a zero or nonzero response length. Random payloads are steered so that roughly half carry masked error bits and half are clean. Because of this, a missed or extra mask bit shows up as a wrong card-error flag. A payload with a distinct value in every byte reveals any swapped byte or reversed register in the word packing. Directed cases check the following:
- card-status bit 3 alone, with the control bit on and off, which separates the optional part of the mask;
- timeout settings 0xFD, 0xFE and 0xFF;
- partial status clears;
- stray response strobes, which must leave every register alone.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;
    localparam int AW        = 4;
    localparam int DW        = 16;
    localparam int NRSP      = 8;
    localparam int RSP_BYTES = 2 * NRSP;
    localparam int RSP_W     = 8 * RSP_BYTES;
    localparam int LEN_W     = $clog2(RSP_BYTES) + 1;

    localparam logic [AW-1:0] A_CMD  = 4'd0;
    localparam logic [AW-1:0] A_ARGL = 4'd1;
    localparam logic [AW-1:0] A_ARGH = 4'd2;
    localparam logic [AW-1:0] A_STAT = 4'd3;
    localparam logic [AW-1:0] A_IEN  = 4'd4;
    localparam logic [AW-1:0] A_CTO  = 4'd5;
    localparam logic [AW-1:0] A_CTRL = 4'd6;

    localparam int ST_DONE  = 0;
    localparam int ST_BUSY  = 2;
    localparam int ST_TMO   = 7;
    localparam int ST_OCRB  = 12;
    localparam int ST_CERR  = 14;
    localparam int CTRL_AKE = 13;

    localparam logic [31:0] R1_ERR_MASK = 32'hFDF8_0000;
    localparam logic [31:0] AKE_BIT     = 32'h0000_0008;
    localparam logic [15:0] R6_ERR_MASK = 16'hE008;
    localparam logic [1:0]  KIND_ADTC   = 2'd3;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_R1   = 3'd1,
        RSP_R2   = 3'd2,
        RSP_R3   = 3'd3,
        RSP_R6   = 3'd6
    } rsp_kind_e;

    typedef struct packed {
        logic       dir;
        logic [1:0] kind;
        logic       busy;
        logic [2:0] rtype;
        logic [5:0] index;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] w);
        cmd_t c;
        c.dir   = w[15];
        c.kind  = w[13:12];
        c.busy  = w[11];
        c.rtype = w[10:8];
        c.index = w[5:0];
        return c;
    endfunction

    function automatic logic r1_card_err(input logic [31:0] cs, input logic ake);
        return |(cs & (R1_ERR_MASK | (ake ? AKE_BIT : 32'd0)));
    endfunction
endpackage

// File: rtl/sdh_cmd_hostregs.sv
module sdh_cmd_hostregs
    import sdh_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          cmd_wr,
    output logic [DW-1:0] cmd_word,
    output logic          cmd_start,
    output logic          fifo_pos_clr,
    output logic [31:0]   arg,
    output logic [DW-1:0] ien,
    output logic [7:0]    cto,
    output logic          ake_en,
    output logic          cto_illegal
);
    assign cmd_wr      = we && (addr == A_CMD);
    assign cto_illegal = (cto[7:1] == 7'h7F);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word     <= '0;
            cmd_start    <= 1'b0;
            fifo_pos_clr <= 1'b0;
            arg          <= '0;
            ien          <= '0;
            cto          <= '0;
            ake_en       <= 1'b0;
        end else begin
            cmd_start    <= cmd_wr;
            fifo_pos_clr <= cmd_wr && (wdata[13:12] == KIND_ADTC);
            if (we) begin
                case (addr)
                    A_CMD:   cmd_word    <= wdata;
                    A_ARGL:  arg[15:0]   <= wdata;
                    A_ARGH:  arg[31:16]  <= wdata;
                    A_IEN:   ien         <= wdata;
                    A_CTO:   cto         <= wdata[7:0];
                    A_CTRL:  ake_en      <= wdata[CTRL_AKE];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdh_rsp_eval.sv
module sdh_rsp_eval
    import sdh_cmd_pkg::*;
(
    input  logic [2:0]       rtype,
    input  logic             busy,
    input  logic             ake_en,
    input  logic [LEN_W-1:0] len,
    input  logic [RSP_W-1:0] bytes,
    output logic [DW-1:0]    set_bits,
    output logic             store
);
    logic [31:0] head;
    logic        has_rsp, tmo;

    assign head    = {bytes[7:0], bytes[15:8], bytes[23:16], bytes[31:24]};
    assign has_rsp = (rtype != RSP_NONE);
    assign tmo     = has_rsp && (len == '0);
    assign store   = has_rsp && !tmo;

    always_comb begin
        set_bits = '0;
        if (tmo) begin
            set_bits[ST_TMO] = 1'b1;
        end else begin
            set_bits[ST_DONE] = 1'b1;
            set_bits[ST_BUSY] = busy;
            case (rtype)
                RSP_R1: set_bits[ST_CERR] = r1_card_err(head, ake_en);
                RSP_R6: set_bits[ST_CERR] = |(head[15:0] & R6_ERR_MASK);
                RSP_R3: set_bits[ST_OCRB] = ~head[31];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdh_rsp_bank.sv
module sdh_rsp_bank
    import sdh_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               load,
    input  logic [RSP_W-1:0]   bytes,
    output logic [NRSP*DW-1:0] words
);
    for (genvar j = 0; j < NRSP; j++) begin : g_word
        localparam int I = NRSP - 1 - j;
        always_ff @(posedge clk) begin
            if (rst || clr)
                words[j*DW +: DW] <= '0;
            else if (load)
                words[j*DW +: DW] <= {bytes[16*I +: 8], bytes[16*I+8 +: 8]};
        end
    end
endmodule

// File: rtl/sdh_cmd_top.sv
module sdh_cmd_top
    import sdh_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [3:0]    host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic          irq,
    output logic          cto_illegal,
    output logic          cmd_start,
    output logic [5:0]    cmd_index,
    output logic [2:0]    cmd_rsp_type,
    output logic [1:0]    cmd_kind,
    output logic          cmd_busy,
    output logic          cmd_dir,
    output logic [31:0]   cmd_arg,
    output logic          fifo_pos_clr,
    input  logic          rsp_valid,
    input  logic [4:0]    rsp_len,
    input  logic [127:0]  rsp_bytes
);
    logic               cmd_wr, ake_en, store, accept, pending_q;
    logic [DW-1:0]      cmd_word, ien, set_bits, stat_q, stat_d;
    logic [7:0]         cto;
    logic [NRSP*DW-1:0] rsp_words;
    cmd_t               cmd;

    sdh_cmd_hostregs u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_start(cmd_start),
        .fifo_pos_clr(fifo_pos_clr), .arg(cmd_arg), .ien(ien), .cto(cto),
        .ake_en(ake_en), .cto_illegal(cto_illegal)
    );

    assign cmd          = decode_cmd(cmd_word);
    assign cmd_index    = cmd.index;
    assign cmd_rsp_type = cmd.rtype;
    assign cmd_kind     = cmd.kind;
    assign cmd_busy     = cmd.busy;
    assign cmd_dir      = cmd.dir;

    sdh_rsp_eval u_eval (
        .rtype(cmd.rtype), .busy(cmd.busy), .ake_en(ake_en), .len(rsp_len),
        .bytes(rsp_bytes), .set_bits(set_bits), .store(store)
    );

    assign accept = rsp_valid && pending_q && !cmd_wr;

    sdh_rsp_bank u_bank (
        .clk(clk), .rst(rst), .clr(cmd_wr), .load(accept && store),
        .bytes(rsp_bytes), .words(rsp_words)
    );

    always_comb begin
        stat_d = stat_q;
        if (host_we && host_addr == A_STAT) stat_d = stat_d & ~host_wdata;
        if (accept) stat_d = stat_d | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (cmd_wr) pending_q <= 1'b1;
            else if (accept) pending_q <= 1'b0;
        end
    end

    assign irq = |(stat_q & ien);

    always_comb begin
        host_rdata = '0;
        if (host_addr[3]) begin
            host_rdata = rsp_words[DW*host_addr[2:0] +: DW];
        end else begin
            case (host_addr)
                A_CMD:   host_rdata = cmd_word;
                A_ARGL:  host_rdata = cmd_arg[15:0];
                A_ARGH:  host_rdata = cmd_arg[31:16];
                A_STAT:  host_rdata = stat_q;
                A_IEN:   host_rdata = ien;
                A_CTO:   host_rdata = {8'd0, cto};
                A_CTRL:  host_rdata = {2'd0, ake_en, 13'd0};
                default: host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sdh_cmd_checker.sv
module sdh_cmd_checker (
    input logic         clk,
    input logic         rst,
    input logic         host_we,
    input logic [3:0]   host_addr,
    input logic [15:0]  host_wdata,
    input logic [15:0]  host_rdata,
    input logic         cmd_start,
    input logic [1:0]   cmd_kind,
    input logic [2:0]   cmd_rsp_type,
    input logic         fifo_pos_clr,
    input logic         cto_illegal,
    input logic         rsp_valid,
    input logic [4:0]   rsp_len,
    input logic [15:0]  stat_q,
    input logic         pending_q
);
    a_r1_start_from_write: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(host_we && host_addr == 4'd0));

    a_r3_fifo_clr_adtc: assert property (@(posedge clk) disable iff (rst)
        fifo_pos_clr |-> (cmd_start && cmd_kind == 2'd3));

    a_r3_rsp_cleared: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 4'd0) |=> (!host_addr[3] || host_rdata == 16'd0));

    a_r8_timeout_flag: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && pending_q && cmd_rsp_type != 3'd0 && rsp_len == 5'd0 &&
         !(host_we && host_addr == 4'd0)) |=> stat_q[7]);

    a_r10_cto_bad: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 4'd5 && host_wdata[7:1] == 7'h7F) |=> cto_illegal);

    a_r11_w1c: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 4'd3 && !rsp_valid) |=> ((stat_q & $past(host_wdata)) == 16'd0));

    a_r12_stray_ignored: assert property (@(posedge clk) disable iff (rst)
        (!pending_q && !host_we) |=> $stable(stat_q));
endmodule

bind sdh_cmd_top sdh_cmd_checker u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_start(cmd_start),
    .cmd_kind(cmd_kind), .cmd_rsp_type(cmd_rsp_type), .fifo_pos_clr(fifo_pos_clr),
    .cto_illegal(cto_illegal), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .stat_q(stat_q), .pending_q(pending_q)
);

// File: tb/sim_sdh_cmd_top.sv
module sim_sdh_cmd_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_we = 1'b0;
    logic [3:0]   host_addr = '0;
    logic [15:0]  host_wdata = '0;
    logic [15:0]  host_rdata;
    logic         irq, cto_illegal, cmd_start, cmd_busy, cmd_dir, fifo_pos_clr;
    logic [5:0]   cmd_index;
    logic [2:0]   cmd_rsp_type;
    logic [1:0]   cmd_kind;
    logic [31:0]  cmd_arg;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;

    int n_chk = 0;
    int n_bad = 0;

    sdh_cmd_top u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic respond(input logic [4:0] len, input logic [127:0] b);
        rsp_valid = 1'b1; rsp_len = len; rsp_bytes = b;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    function automatic logic [7:0] byt(input logic [127:0] b, input int k);
        return b[8*k +: 8];
    endfunction

    function automatic logic [15:0] exp_stat(input logic [2:0] rt, input logic busy,
            input logic ake, input logic [4:0] len, input logic [127:0] b);
        logic [15:0] s;
        logic [31:0] cs;
        s = '0;
        cs = {byt(b,0), byt(b,1), byt(b,2), byt(b,3)};
        if (rt != 0 && len == 0) return 16'h0080;
        s[0] = 1'b1;
        s[2] = busy;
        if (rt == 3'd1) s[14] = |(cs & (32'hFDF80000 | (ake ? 32'h8 : 32'h0)));
        if (rt == 3'd6) s[14] = |(cs[15:0] & 16'hE008);
        if (rt == 3'd3) s[12] = ~cs[31];
        return s;
    endfunction

    task automatic check_rsp(input string tag, input logic stored, input logic [127:0] b);
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(4'd8 + 4'(7 - i), v);
            chk(tag, v, stored ? {byt(b, 2*i), byt(b, 2*i+1)} : 16'h0);
        end
    endtask

    task automatic run_cmd(input logic [15:0] cw, input logic [31:0] a, input logic ake,
            input logic [15:0] ien, input logic [4:0] len, input logic [127:0] b);
        logic [15:0] v, es;
        wr(4'd3, 16'hFFFF);
        wr(4'd6, {2'b0, ake, 13'b0});
        wr(4'd4, ien);
        wr(4'd1, a[15:0]);
        wr(4'd2, a[31:16]);
        wr(4'd0, cw);
        chk("R1 start", cmd_start, 1);
        chk("R1 fields", {cmd_dir, cmd_kind, cmd_busy, cmd_rsp_type, cmd_index},
            {cw[15], cw[13:12], cw[11], cw[10:8], cw[5:0]});
        chk("R2 arg", cmd_arg, a);
        chk("R3 fifo clr", fifo_pos_clr, cw[13:12] == 2'd3);
        respond(len, b);
        chk("R1 start one cycle", cmd_start, 0);
        es = exp_stat(cw[10:8], cw[11], ake, len, b);
        rd(4'd3, v);
        chk("R5 R6 R7 R8 R9 status", v, es);
        chk("R11 irq", irq, |(es & ien));
        check_rsp("R4 rsp pack", cw[10:8] != 0 && len != 0, b);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog got=hang exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0]  v;
        logic [127:0] b;
        logic [2:0]   rt;
        logic [15:0]  cw;
        logic [31:0]  a;
        logic [2:0]   types [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(4'd3, v); chk("R11 reset stat", v, 0);
        chk("R11 reset irq", irq, 0);
        chk("R1 reset start", cmd_start, 0);
        check_rsp("R4 reset rsp", 1'b0, '0);

        // R2 halves
        wr(4'd1, 16'h1234); wr(4'd2, 16'hABCD);
        wr(4'd1, 16'h5678);
        rd(4'd1, v); chk("R2 argl", v, 16'h5678);
        rd(4'd2, v); chk("R2 argh", v, 16'hABCD);
        chk("R2 arg port", cmd_arg, 32'hABCD5678);

        // R10 timeout setting
        wr(4'd5, 16'h00FD); chk("R10 fd", cto_illegal, 0);
        wr(4'd5, 16'h00FE); chk("R10 fe", cto_illegal, 1);
        wr(4'd5, 16'h00FF); chk("R10 ff", cto_illegal, 1);
        wr(4'd5, 16'h0040); chk("R10 40", cto_illegal, 0);

        // R4 distinct-byte packing, R2 type
        for (int k = 0; k < 16; k++) b[8*k +: 8] = 8'(8'h10 + k);
        run_cmd(16'h0202, 32'h0, 1'b0, 16'h0001, 5'd16, b);
        rd(4'd15, v); chk("R4 reg7", v, 16'h1011);
        rd(4'd8,  v); chk("R4 reg0", v, 16'h1E1F);

        // R3 clear and ADTC clear pulse
        wr(4'd0, 16'h3111);
        chk("R3 adtc clr", fifo_pos_clr, 1);
        check_rsp("R3 rsp cleared", 1'b0, '0);
        respond(5'd6, '0);

        // R5 bit 3 only, with and without control bit
        b = '0; b[31:24] = 8'h08;
        run_cmd(16'h0111, 32'h0, 1'b0, 16'h4000, 5'd6, b);
        rd(4'd3, v); chk("R5 ake off", v[14], 0);
        run_cmd(16'h0111, 32'h0, 1'b1, 16'h4000, 5'd6, b);
        rd(4'd3, v); chk("R5 ake on", v[14], 1);

        // R8 timeout with busy command
        run_cmd(16'h0911, 32'h0, 1'b0, 16'h0080, 5'd0, b);
        rd(4'd3, v); chk("R8 timeout only", v, 16'h0080);
        chk("R8 irq", irq, 1);

        // R11 partial clear, then R12 stray strobe
        run_cmd(16'h0800, 32'h0, 1'b0, 16'h0004, 5'd6, b);
        wr(4'd3, 16'h0001);
        rd(4'd3, v); chk("R11 partial clear", v, 16'h0004);
        chk("R11 irq stays", irq, 1);
        wr(4'd3, 16'h0004);
        chk("R11 irq drops", irq, 0);
        for (int k = 0; k < 16; k++) b[8*k +: 8] = 8'hA5;
        respond(5'd16, b);
        rd(4'd3, v); chk("R12 stray stat", v, 0);
        check_rsp("R12 stray rsp", 1'b0, '0);

        // random commands
        for (int it = 0; it < 300; it++) begin
            rt = types[$urandom % 5];
            cw = 16'($urandom);
            cw[10:8] = rt;
            a = $urandom;
            for (int k = 0; k < 4; k++) b[32*k +: 32] = $urandom;
            if ($urandom % 2) begin
                b[7:0] = 8'h0; b[15:8] = 8'h0; b[31:24] = b[31:24] & 8'hF7;
                if (rt == 3'd6) b[23:16] = b[23:16] & 8'h1F;
            end
            run_cmd(cw, a, 1'($urandom), 16'($urandom), ($urandom % 4 == 0) ? 5'd0 : 5'd16, b);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule